// File: doc/BRIEF.md
# Speculative Register and Store Checkpoint Unit

This unit keeps the speculative processor state of one translated code block so that the block either takes effect as a whole or leaves no trace. Each architectural register exists twice: a working value that instructions read and write, and a shadow value that holds the last committed state. Stores from the block wait in an ordered buffer, and loads look into that buffer before going to memory.

When the block ends normally, a commit pulse copies every working register into its shadow in one cycle. The same pulse starts a drain that writes the buffered stores to memory in program order, one per cycle. When an exception is detected, a rollback pulse restores every working register from its shadow in one cycle and drops all stores that have not been committed. The block can then be re-executed from the last committed point. Stores that a commit has already released still drain after a rollback.

Top module: `ckpt_state_unit`

## Requirements
- R1: After synchronous reset, every working and shadow register reads 0, the store buffer is empty (loads miss with `ld_hit`=0 and `ld_data`=0) and `mem_we` is 0.
- R2: The read ports return the working copy combinationally. When `wr_en` is high and `wr_addr` equals a read address in the same cycle, that port returns `wr_data`. The written value is visible from the next cycle on.
- R3: A register write changes only the working copy. A rollback with no commit since the write brings back the older value.
- R4: A commit copies all working registers into their shadows in one cycle. A write in the commit cycle is included in the copy.
- R5: A rollback restores every working register from its shadow in one cycle. A register write in the rollback cycle is dropped. A commit and a rollback in the same cycle act as a rollback alone.
- R6: Buffered stores never reach the memory port before a commit. `mem_we` first rises two clock edges after the edge that samples the commit.
- R7: A load whose address matches buffered stores sets `ld_hit`=1 and returns the data of the youngest matching store. A load that matches nothing gives `ld_hit`=0 and `ld_data`=0. A store enqueued in the same cycle as the load is not visible to that load.
- R8: The buffer holds `SB_DEPTH` (8) stores. A store request while the buffer is full raises `st_stall` and is not accepted.
- R9: After a commit with a non-empty buffer, the stores leave on `mem_we`/`mem_addr`/`mem_data` in enqueue order, one per cycle with no gaps, until the buffer is empty.
- R10: While a post-commit drain is in progress, every store request is refused with `st_stall`. A rollback during the drain does not stop or alter the drain.
- R11: A rollback when no drain is in progress discards every buffered store, including one offered in the same cycle. None of them ever reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr0 | input | 4 | Register index for read port 0 |
| rd_data0 | output | 32 | Working value read on port 0 |
| rd_addr1 | input | 4 | Register index for read port 1 |
| rd_data1 | output | 32 | Working value read on port 1 |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register index to write |
| wr_data | input | 32 | Register write value |
| st_req | input | 1 | Store enqueue request |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_stall | output | 1 | Store request refused in this cycle |
| ld_addr | input | 32 | Load address to look up in the buffer |
| ld_hit | output | 1 | Buffer holds a store to `ld_addr` |
| ld_data | output | 32 | Data of the youngest matching store |
| commit | input | 1 | End-of-block commit pulse |
| rollback | input | 1 | Discard speculative state pulse |
| mem_we | output | 1 | Registered memory write strobe |
| mem_addr | output | 32 | Registered memory write address |
| mem_data | output | 32 | Registered memory write data |

## Verification
The bound checker watches several rules on every cycle: the refusal of stores while the buffer is full or draining, the flush of the buffer on a rollback outside a drain, the rule that a drain starts only two edges after a commit and ends with a final memory write, and the visibility of a register write one cycle later. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact values restored by rollback and kept by commit, the choice of the youngest of several matching stores, and the order of addresses leaving during a drain. It also covers a drain that continues through a rollback.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  // Store buffer operating mode: gathering stores of the open block,
  // or releasing committed stores to memory.
  typedef enum logic {
    SB_GATHER  = 1'b0,
    SB_RELEASE = 1'b1
  } sb_mode_e;

endpackage

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] rd_addr0,
  output logic [DATA_W-1:0] rd_data0,
  input  logic [RIDX_W-1:0] rd_addr1,
  output logic [DATA_W-1:0] rd_data1,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              rollback
);

  logic [DATA_W-1:0] work_q   [NUM_REGS];
  logic [DATA_W-1:0] shadow_q [NUM_REGS];

  // Each register is a working/shadow pair; all pairs move together on
  // commit or rollback, so they are built as flops rather than RAM.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pair
    logic hit_w;
    assign hit_w = wr_en && (wr_addr == RIDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        work_q[g]   <= '0;
        shadow_q[g] <= '0;
      end else if (rollback) begin
        work_q[g] <= shadow_q[g];
      end else begin
        if (hit_w)  work_q[g]   <= wr_data;
        if (commit) shadow_q[g] <= hit_w ? wr_data : work_q[g];
      end
    end
  end

  // Working copy read with same-cycle write bypass.
  always_comb begin
    rd_data0 = work_q[rd_addr0];
    rd_data1 = work_q[rd_addr1];
    if (wr_en && wr_addr == rd_addr0) rd_data0 = wr_data;
    if (wr_en && wr_addr == rd_addr1) rd_data1 = wr_data;
  end

endmodule

// File: rtl/ckpt_store_buf.sv
module ckpt_store_buf
  import ckpt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SB_DEPTH = 8,
  localparam int PTR_W   = $clog2(SB_DEPTH),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_stall,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  input  logic              commit,
  input  logic              rollback,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              busy,
  output logic              full
);

  logic [ADDR_W-1:0] ent_addr [SB_DEPTH];
  logic [DATA_W-1:0] ent_data [SB_DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q, count_nx;
  sb_mode_e          mode_q;
  logic              accept;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy     = (mode_q == SB_RELEASE);
  assign full     = (count_q == CNT_W'(SB_DEPTH));
  assign accept   = st_req && !full && !busy;
  assign st_stall = st_req && !accept;
  assign count_nx = count_q + CNT_W'(accept);

  // Entry storage: one write port at the tail, no reset.
  always_ff @(posedge clk) begin
    if (accept) begin
      ent_addr[tail_q] <= st_addr;
      ent_data[tail_q] <= st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= '0;
      tail_q   <= '0;
      count_q  <= '0;
      mode_q   <= SB_GATHER;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        // Committed stores leave oldest first, one per cycle.
        mem_we   <= 1'b1;
        mem_addr <= ent_addr[head_q];
        mem_data <= ent_data[head_q];
        head_q   <= ptr_inc(head_q);
        count_q  <= count_q - 1'b1;
        if (count_q == CNT_W'(1)) mode_q <= SB_GATHER;
      end else if (rollback) begin
        head_q  <= '0;
        tail_q  <= '0;
        count_q <= '0;
      end else begin
        if (accept) tail_q <= ptr_inc(tail_q);
        count_q <= count_nx;
        if (commit && count_nx != '0) mode_q <= SB_RELEASE;
      end
    end
  end

  // Snoop: scan oldest to youngest so the youngest match wins.
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      int unsigned pos;
      pos = (int'(head_q) + i) % SB_DEPTH;
      if (CNT_W'(i) < count_q && ent_addr[pos] == ld_addr) begin
        ld_hit  = 1'b1;
        ld_data = ent_data[pos];
      end
    end
  end

endmodule

// File: rtl/ckpt_state_unit.sv
module ckpt_state_unit #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int SB_DEPTH = 8,
  localparam int RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] rd_addr0,
  output logic [DATA_W-1:0] rd_data0,
  input  logic [RIDX_W-1:0] rd_addr1,
  output logic [DATA_W-1:0] rd_data1,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_stall,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  input  logic              commit,
  input  logic              rollback,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);

  logic sb_busy;
  logic sb_full;

  ckpt_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_addr0 (rd_addr0),
    .rd_data0 (rd_data0),
    .rd_addr1 (rd_addr1),
    .rd_data1 (rd_data1),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .commit   (commit),
    .rollback (rollback)
  );

  ckpt_store_buf #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SB_DEPTH (SB_DEPTH)
  ) u_sbuf (
    .clk      (clk),
    .rst      (rst),
    .st_req   (st_req),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .st_stall (st_stall),
    .ld_addr  (ld_addr),
    .ld_hit   (ld_hit),
    .ld_data  (ld_data),
    .commit   (commit),
    .rollback (rollback),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .busy     (sb_busy),
    .full     (sb_full)
  );

endmodule

// File: rtl/ckpt_state_chk.sv
module ckpt_state_chk #(
  parameter int RIDX_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [RIDX_W-1:0] rd_addr0,
  input logic [DATA_W-1:0] rd_data0,
  input logic              wr_en,
  input logic [RIDX_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              st_req,
  input logic              st_stall,
  input logic              commit,
  input logic              rollback,
  input logic              mem_we,
  input logic              sb_busy,
  input logic              sb_full
);

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rollback) ##1 (rd_addr0 == $past(wr_addr) && !(wr_en && wr_addr == rd_addr0))
    |-> rd_data0 == $past(wr_data));

  assert_drain_after_commit_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(commit, 2) && !$past(rollback, 2)));

  assert_stall_full_R8: assert property (@(posedge clk) disable iff (rst)
    (st_req && sb_full) |-> st_stall);

  assert_full_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (sb_full && !sb_busy && !rollback) |=> sb_full);

  assert_drain_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(sb_busy) |-> mem_we);

  assert_stall_drain_R10: assert property (@(posedge clk) disable iff (rst)
    (sb_busy && st_req) |-> st_stall);

  assert_rollback_flush_R11: assert property (@(posedge clk) disable iff (rst)
    (rollback && !sb_busy) |=> (!sb_busy && !sb_full));

endmodule

bind ckpt_state_unit ckpt_state_chk #(
  .RIDX_W (RIDX_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_addr0 (rd_addr0),
  .rd_data0 (rd_data0),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .st_req   (st_req),
  .st_stall (st_stall),
  .commit   (commit),
  .rollback (rollback),
  .mem_we   (mem_we),
  .sb_busy  (sb_busy),
  .sb_full  (sb_full)
);

// File: tb/test_ckpt_state_unit.sv
module test_ckpt_state_unit;

  localparam int NREG  = 16;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    rd_addr0, rd_addr1, wr_addr;
  logic [DW-1:0] rd_data0, rd_data1, wr_data, st_data, ld_data, mem_data;
  logic [AW-1:0] st_addr, ld_addr, mem_addr;
  logic          wr_en, st_req, st_stall, ld_hit, commit, rollback, mem_we;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ckpt_state_unit i_ckpt_state_unit (
    .clk(clk), .rst(rst),
    .rd_addr0(rd_addr0), .rd_data0(rd_data0),
    .rd_addr1(rd_addr1), .rd_data1(rd_data1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .commit(commit), .rollback(rollback),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // Behavioural reference model
  logic [DW-1:0] m_work   [NREG];
  logic [DW-1:0] m_shadow [NREG];
  logic [AW-1:0] m_qa [$];
  logic [DW-1:0] m_qd [$];
  bit            m_busy;
  logic          m_mem_we;
  logic [AW-1:0] m_mem_addr;
  logic [DW-1:0] m_mem_data;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin m_work[i] = '0; m_shadow[i] = '0; end
    m_qa.delete(); m_qd.delete();
    m_busy = 0; m_mem_we = 0; m_mem_addr = '0; m_mem_data = '0;
  endtask

  task automatic model_update();
    bit acc;
    acc = st_req && !m_busy && (m_qa.size() < DEPTH);
    if (rollback) begin
      for (int i = 0; i < NREG; i++) m_work[i] = m_shadow[i];
    end else begin
      if (wr_en) m_work[wr_addr] = wr_data;
      if (commit) for (int i = 0; i < NREG; i++) m_shadow[i] = m_work[i];
    end
    m_mem_we = 0;
    if (m_busy) begin
      m_mem_we   = 1;
      m_mem_addr = m_qa.pop_front();
      m_mem_data = m_qd.pop_front();
      if (m_qa.size() == 0) m_busy = 0;
    end else if (rollback) begin
      m_qa.delete(); m_qd.delete();
    end else begin
      if (acc) begin m_qa.push_back(st_addr); m_qd.push_back(st_data); end
      if (commit && m_qa.size() > 0) m_busy = 1;
    end
  endtask

  task automatic compare_all();
    logic [DW-1:0] e0, e1, ed;
    bit eh;
    e0 = (wr_en && wr_addr == rd_addr0) ? wr_data : m_work[rd_addr0];
    e1 = (wr_en && wr_addr == rd_addr1) ? wr_data : m_work[rd_addr1];
    chk(rd_data0 === e0, "R2 rd0", rd_data0, e0);
    chk(rd_data1 === e1, "R2 rd1", rd_data1, e1);
    eh = 0; ed = '0;
    for (int i = 0; i < m_qa.size(); i++)
      if (m_qa[i] == ld_addr) begin eh = 1; ed = m_qd[i]; end
    chk(ld_hit === eh, "R7 hit", ld_hit, eh);
    chk(ld_data === ed, "R7 data", ld_data, ed);
    chk(st_stall === (st_req && (m_busy || m_qa.size() == DEPTH)), "R8 stall",
        st_stall, st_req && (m_busy || m_qa.size() == DEPTH));
    chk(mem_we === m_mem_we, "R6 mem_we", mem_we, m_mem_we);
    if (m_mem_we) begin
      chk(mem_addr === m_mem_addr, "R9 mem_addr", mem_addr, m_mem_addr);
      chk(mem_data === m_mem_data, "R9 mem_data", mem_data, m_mem_data);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = '0; wr_data = '0;
    st_req = 0; st_addr = '0; st_data = '0;
    commit = 0; rollback = 0;
  endtask

  // One clock: settle, compare with model, take the edge, advance model.
  task automatic step();
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_req = 1; st_addr = a; st_data = d;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    rd_addr0 = '0; rd_addr1 = '0; ld_addr = '0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state
    rd_addr0 = 4'd0; rd_addr1 = 4'd15; ld_addr = 32'h0;
    #1;
    chk(rd_data0 === 32'h0, "R1 reg0", rd_data0, 0);
    chk(rd_data1 === 32'h0, "R1 reg15", rd_data1, 0);
    chk(mem_we === 1'b0, "R1 mem_we", mem_we, 0);
    chk(ld_hit === 1'b0, "R1 ld_hit", ld_hit, 0);
    step();

    // R2: write every register with same-cycle bypass on port 0
    for (int r = 0; r < NREG; r++) begin
      wr_en = 1; wr_addr = 4'(r); wr_data = 32'hA000_0000 + r; rd_addr0 = 4'(r);
      #1;
      chk(rd_data0 === 32'hA000_0000 + r, "R2 bypass", rd_data0, 32'hA000_0000 + r);
      step();
    end
    rd_addr0 = 4'd5; rd_addr1 = 4'd9;
    #1;
    chk(rd_data1 === 32'hA000_0009, "R2 stored", rd_data1, 32'hA000_0009);
    step();

    // R3: writes never committed are undone by rollback
    rollback = 1;
    step();
    rd_addr0 = 4'd5;
    #1;
    chk(rd_data0 === 32'h0, "R3 working reverted", rd_data0, 0);
    step();

    // R4: commit includes same-cycle write
    for (int r = 0; r < 4; r++) begin
      wr_en = 1; wr_addr = 4'(r); wr_data = 32'hB000_0000 + r;
      if (r == 3) commit = 1;
      step();
    end
    wr_en = 1; wr_addr = 4'd2; wr_data = 32'hDEAD_BEEF;
    step();
    // R5: rollback drops same-cycle write
    rollback = 1; wr_en = 1; wr_addr = 4'd1; wr_data = 32'h5555_5555;
    step();
    rd_addr0 = 4'd2; rd_addr1 = 4'd3;
    #1;
    chk(rd_data0 === 32'hB000_0002, "R4 shadow restored", rd_data0, 32'hB000_0002);
    chk(rd_data1 === 32'hB000_0003, "R4 commit-cycle write", rd_data1, 32'hB000_0003);
    step();
    rd_addr0 = 4'd1;
    #1;
    chk(rd_data0 === 32'hB000_0001, "R5 write dropped", rd_data0, 32'hB000_0001);
    step();
    // R5: commit with rollback acts as rollback
    wr_en = 1; wr_addr = 4'd0; wr_data = 32'h1234; commit = 1; rollback = 1;
    step();
    rd_addr0 = 4'd0;
    #1;
    chk(rd_data0 === 32'hB000_0000, "R5 commit+rollback", rd_data0, 32'hB000_0000);
    step();

    // R7: youngest matching store wins
    store(32'h100, 32'h11);
    store(32'h104, 32'h22);
    st_req = 1; st_addr = 32'h100; st_data = 32'h33; ld_addr = 32'h100;
    #1;
    chk(ld_data === 32'h11, "R7 same-cycle enqueue invisible", ld_data, 32'h11);
    step();
    ld_addr = 32'h100;
    #1;
    chk(ld_hit === 1'b1 && ld_data === 32'h33, "R7 youngest", ld_data, 32'h33);
    step();
    ld_addr = 32'h104;
    #1;
    chk(ld_data === 32'h22, "R7 older entry", ld_data, 32'h22);
    step();
    ld_addr = 32'h108;
    #1;
    chk(ld_hit === 1'b0, "R7 miss", ld_hit, 0);
    step();
    repeat (3) step();
    chk(mem_we === 1'b0, "R6 no write before commit", mem_we, 0);

    // R11: rollback outside drain discards stores
    rollback = 1; st_req = 1; st_addr = 32'h10C; st_data = 32'h44;
    step();
    ld_addr = 32'h100;
    #1;
    chk(ld_hit === 1'b0, "R11 flushed", ld_hit, 0);
    step();
    ld_addr = 32'h10C;
    #1;
    chk(ld_hit === 1'b0, "R11 same-cycle store dropped", ld_hit, 0);
    step();
    commit = 1;
    step();
    repeat (3) begin
      #1;
      chk(mem_we === 1'b0, "R11 nothing drained", mem_we, 0);
      step();
    end

    // R8: fill buffer, ninth request stalls
    for (int i = 0; i < DEPTH; i++) store(32'h200 + 4 * i, 32'h1 + i);
    st_req = 1; st_addr = 32'h300; st_data = 32'h99;
    #1;
    chk(st_stall === 1'b1, "R8 full stall", st_stall, 1);
    step();
    ld_addr = 32'h300;
    #1;
    chk(ld_hit === 1'b0, "R8 refused store absent", ld_hit, 0);
    step();

    // R9/R10: drain in order, stalls during drain, rollback ignored
    commit = 1;
    step();
    for (int i = 0; i < DEPTH; i++) begin
      st_req = 1; st_addr = 32'h400; st_data = 32'h77;
      if (i == 3) rollback = 1;
      #1;
      chk(st_stall === 1'b1, "R10 stall during drain", st_stall, 1);
      step();
      #1;
      chk(mem_we === 1'b1 && mem_addr === 32'h200 + 4 * i, "R9 drain order",
          mem_addr, 32'h200 + 4 * i);
    end
    step();
    #1;
    chk(mem_we === 1'b0, "R9 drain ended", mem_we, 0);
    st_req = 1; st_addr = 32'h500; st_data = 32'h5;
    #1;
    chk(st_stall === 1'b0, "R10 accepted after drain", st_stall, 0);
    step();
    rollback = 1;
    step();
    repeat (2) step();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule